// File: doc/BRIEF.md
# Cycle-Steal Memory Loader Sequencer

This block loads one operator-supplied word into processor memory for each command it accepts. It uses the processor's cycle-steal (direct memory access) path. A command carries an address and a data word, and the block latches both when it accepts the command. It then waits until the processor reports that it has halted. Only then does it raise a cycle-steal request. When a grant comes back, the request is withdrawn at once, so the processor performs exactly one stolen memory cycle. The latched address and data stay on the memory buses while the memory-cycle phase strobe marks the stolen access.

Three processor signals come from another clock domain: the halted status, the grant and the phase strobe. Each passes through a two-flop synchronizer and is used only as a level, never as an edge. A narrow glitch between clock edges therefore cannot start, advance or end an access. If no grant arrives within a run-time timeout, the request is withdrawn and a one-cycle error pulse is given. When the strobe finishes, a one-cycle done pulse reports completion. The block refuses the next command until the grant line has gone low again.

Top module: `csteal_loader`

## Requirements
- R1: After reset, `steal_req`, `done`, `err` and `bus_drive` are low, and `cmd_ready` is high while `grant_in` is low.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Its address and data appear on `mem_addr` and `mem_data` and stay unchanged until the access ends, even if the command inputs change. `cmd_ready` is low from the accepting edge until the sequence is back in idle.
- R3: `steal_req` rises only while the synchronized halted status is high. A command stays pending, with the request low, for as long as `cpu_halted` is low. If `cpu_halted` is already high, the request rises on the first edge after acceptance.
- R4: `cpu_halted`, `grant_in` and `strobe_in` each pass through two flops before any use. A level change therefore acts on the third rising edge after it. A pulse that lies wholly between two rising edges has no effect.
- R5: Once the synchronized grant is seen during the request, `steal_req` drops and `bus_drive` rises on the third rising edge after `grant_in` went high.
- R6: `done` is a one-cycle pulse on the third rising edge after `strobe_in` falls, provided the strobe was first seen high during the granted phase. `bus_drive` falls on that same edge.
- R7: While `grant_in` stays high after an access, `cmd_ready` stays low. It rises on the second rising edge after `grant_in` falls.
- R8: With timeout value L, the request stays high for max(L,1) cycles if no grant is seen. It then drops, `err` pulses for one cycle, and the sequencer returns to idle.
- R9: If the synchronized halted status falls while the request is up, the request drops on the third edge after `cpu_halted` fell. It is raised again on the third edge after `cpu_halted` returns high, and the timeout restarts.
- R10: Each command yields one request only. After `done`, `steal_req` stays low until a new command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Load command offered |
| cmd_ready | output | 1 | Loader can take a command |
| cmd_addr | input | AW | Target memory address |
| cmd_data | input | DW | Word to write |
| timeout_lim | input | TW | Request cycles allowed before giving up |
| cpu_halted | input | 1 | Processor halted status (asynchronous) |
| grant_in | input | 1 | Cycle-steal grant (asynchronous) |
| strobe_in | input | 1 | Stolen memory-cycle phase strobe (asynchronous) |
| steal_req | output | 1 | Cycle-steal request |
| bus_drive | output | 1 | Address and data are being presented for the stolen cycle |
| mem_addr | output | AW | Latched address |
| mem_data | output | DW | Latched data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle grant timeout pulse |

## Verification
Each processor input reaches the sequencer two flops late. A registered result therefore changes on the third rising edge after an input change, while `cmd_ready` follows the synchronized grant and changes on the second edge. Results that depend only on the sequencer's own state, such as the request after an accepted command, change on the next edge. The bench drives inputs on falling edges and samples outputs on the same falling edges. For each result it checks the sample just before the due edge and the one just after it. The timeout is measured by counting the falling-edge samples with the request high, and that count is compared against max(L,1).

// File: rtl/csteal_loader_pkg.sv
package csteal_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT    = 3'd1,
    ST_REQUEST = 3'd2,
    ST_GRANTED = 3'd3,
    ST_DONE    = 3'd4
  } ld_state_t;
endpackage

// File: rtl/csteal_sync.sv
module csteal_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= async_in[i];
        stage2 <= stage1;
      end
    end
    assign sync_out[i] = stage2;
  end
endmodule

// File: rtl/csteal_timer.sv
module csteal_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  localparam int CW = TW + 1;
  logic [TW-1:0] cnt;
  logic [CW-1:0] next_cnt;

  assign next_cnt = {1'b0, cnt} + CW'(1);
  assign expire   = run && (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!expire) cnt <= next_cnt[TW-1:0];
  end
endmodule

// File: rtl/csteal_fsm.sv
module csteal_fsm
  import csteal_loader_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          halted_s,
  input  logic          grant_s,
  input  logic          strobe_s,
  input  logic          expire,
  output logic          ready,
  output logic          timer_run,
  output logic          busy,
  output logic          req_q,
  output logic          bus_en_q,
  output logic          done_q,
  output logic          err_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);
  ld_state_t state;
  logic      seen_q;

  assign ready     = (state == ST_IDLE) && !grant_s;
  assign timer_run = (state == ST_REQUEST);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      req_q    <= 1'b0;
      bus_en_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      seen_q   <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid && ready) begin
            addr_q <= cmd_addr;
            data_q <= cmd_data;
            state  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (halted_s) begin
            req_q <= 1'b1;
            state <= ST_REQUEST;
          end
        end
        ST_REQUEST: begin
          if (grant_s) begin
            req_q    <= 1'b0;
            bus_en_q <= 1'b1;
            seen_q   <= 1'b0;
            state    <= ST_GRANTED;
          end else if (!halted_s) begin
            req_q <= 1'b0;
            state <= ST_WAIT;
          end else if (expire) begin
            req_q <= 1'b0;
            err_q <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_GRANTED: begin
          if (strobe_s) begin
            seen_q <= 1'b1;
          end else if (seen_q) begin
            bus_en_q <= 1'b0;
            done_q   <= 1'b1;
            state    <= ST_DONE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csteal_loader.sv
module csteal_loader #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic [TW-1:0] timeout_lim,
  input  logic          cpu_halted,
  input  logic          grant_in,
  input  logic          strobe_in,
  output logic          steal_req,
  output logic          bus_drive,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          done,
  output logic          err
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] sync_vec;
  logic halted_s, grant_s, strobe_s;
  logic expire, timer_run, busy;

  csteal_sync #(.W(NSYNC)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({strobe_in, grant_in, cpu_halted}),
    .sync_out (sync_vec)
  );
  assign halted_s = sync_vec[0];
  assign grant_s  = sync_vec[1];
  assign strobe_s = sync_vec[2];

  csteal_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (timer_run),
    .limit  (timeout_lim),
    .expire (expire)
  );

  csteal_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .halted_s  (halted_s),
    .grant_s   (grant_s),
    .strobe_s  (strobe_s),
    .expire    (expire),
    .ready     (cmd_ready),
    .timer_run (timer_run),
    .busy      (busy),
    .req_q     (steal_req),
    .bus_en_q  (bus_drive),
    .done_q    (done),
    .err_q     (err),
    .addr_q    (mem_addr),
    .data_q    (mem_data)
  );
endmodule

// File: rtl/csteal_loader_chk.sv
module csteal_loader_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          steal_req,
  input logic          bus_drive,
  input logic          cmd_ready,
  input logic          done,
  input logic          err,
  input logic          halted_s,
  input logic          grant_s,
  input logic          busy,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data
);
  // R3: a request only rises after the synchronized halted status was high
  p_req_needs_halt_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(steal_req) |-> $past(halted_s));

  // R5: a confirmed grant withdraws the request on the next edge
  p_drop_on_grant_r5: assert property (@(posedge clk) disable iff (rst)
    (steal_req && grant_s) |=> !steal_req);

  // R2: latched address and data stay put while a command is in flight
  p_hold_addr_r2: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(mem_addr) && $stable(mem_data)));

  // R6: done lasts one cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: no command is taken while the grant is still seen high
  p_ready_grant_low_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !grant_s);

  // R8: a timeout error never coexists with a live request or bus drive
  p_err_clean_r8: assert property (@(posedge clk) disable iff (rst)
    err |-> (!steal_req && !bus_drive && $onehot0({done, err})));

  // R10: request and bus drive never overlap
  p_single_phase_r10: assert property (@(posedge clk) disable iff (rst)
    !(steal_req && bus_drive));
endmodule

bind csteal_loader csteal_loader_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .steal_req (steal_req),
  .bus_drive (bus_drive),
  .cmd_ready (cmd_ready),
  .done      (done),
  .err       (err),
  .halted_s  (halted_s),
  .grant_s   (grant_s),
  .busy      (busy),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data)
);

// File: tb/test_csteal_loader.sv
module test_csteal_loader;
  localparam int CLK_NS = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic [TW-1:0] timeout_lim = 8'd200;
  logic          cpu_halted = 1'b0;
  logic          grant_in = 1'b0;
  logic          strobe_in = 1'b0;
  logic          steal_req, bus_drive, done, err;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  csteal_loader #(.AW(AW), .DW(DW), .TW(TW)) i_csteal_loader (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .timeout_lim(timeout_lim),
    .cpu_halted(cpu_halted), .grant_in(grant_in), .strobe_in(strobe_in),
    .steal_req(steal_req), .bus_drive(bus_drive), .mem_addr(mem_addr),
    .mem_data(mem_data), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Offer a command; returns at the negedge after the accepting edge.
  task automatic issue(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmd_addr  = a;
    cmd_data  = d;
    cmd_valid = 1'b1;
    cyc(1);
    cmd_valid = 1'b0;
    cmd_addr  = ~a;
    cmd_data  = ~d;
  endtask

  // Starting at a negedge with steal_req high: grant, strobe, release grant.
  task automatic complete_access(input string tag);
    grant_in = 1'b1;
    cyc(2);
    chk(steal_req == 1'b1, {tag, " R5 req before grant edge"}, steal_req, 1);
    cyc(1);
    chk(steal_req == 1'b0 && bus_drive == 1'b1, {tag, " R5 req drop"}, steal_req, 0);
    strobe_in = 1'b1;
    cyc(3);
    strobe_in = 1'b0;
    cyc(2);
    chk(done == 1'b0, {tag, " R6 done early"}, done, 0);
    cyc(1);
    chk(done == 1'b1 && bus_drive == 1'b0, {tag, " R6 done pulse"}, done, 1);
    cyc(1);
    chk(done == 1'b0, {tag, " R6 done width"}, done, 0);
    chk(cmd_ready == 1'b0, {tag, " R7 ready held by grant"}, cmd_ready, 0);
    cyc(3);
    chk(steal_req == 1'b0 && cmd_ready == 1'b0, {tag, " R10 no second request"}, steal_req, 0);
    grant_in = 1'b0;
    cyc(1);
    chk(cmd_ready == 1'b0, {tag, " R7 ready early"}, cmd_ready, 0);
    cyc(1);
    chk(cmd_ready == 1'b1, {tag, " R7 ready back"}, cmd_ready, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cyc(4);
    rst = 1'b0;
    cyc(1);
    chk(steal_req == 0 && done == 0 && err == 0 && bus_drive == 0, "R1 outputs idle", steal_req, 0);
    chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
  endtask

  task automatic t_basic();
    cpu_halted = 1'b1;
    cyc(3);
    issue(16'h1234, 16'hBEEF);
    chk(cmd_ready == 1'b0, "R2 ready low after accept", cmd_ready, 0);
    chk(steal_req == 1'b0, "R3 req not yet", steal_req, 0);
    cyc(1);
    chk(steal_req == 1'b1, "R3 req one edge after accept", steal_req, 1);
    chk(mem_addr == 16'h1234, "R2 address presented", mem_addr, 16'h1234);
    chk(mem_data == 16'hBEEF, "R2 data presented", mem_data, 16'hBEEF);
    complete_access("basic");
    chk(mem_addr == 16'h1234 && mem_data == 16'hBEEF, "R2 held through access", mem_addr, 16'h1234);
  endtask

  task automatic t_running_block();
    cpu_halted = 1'b0;
    cyc(3);
    issue(16'h0042, 16'h5555);
    cyc(6);
    chk(steal_req == 1'b0, "R3 blocked while running", steal_req, 0);
    // narrow glitch between edges, well away from any rising edge
    #1 cpu_halted = 1'b1;
    #2 cpu_halted = 1'b0;
    cyc(5);
    chk(steal_req == 1'b0, "R4 glitch ignored", steal_req, 0);
    cpu_halted = 1'b1;
    cyc(2);
    chk(steal_req == 1'b0, "R4 req before third edge", steal_req, 0);
    cyc(1);
    chk(steal_req == 1'b1, "R4 req on third edge", steal_req, 1);
    chk(mem_addr == 16'h0042, "R2 address kept while waiting", mem_addr, 16'h0042);
    complete_access("running");
  endtask

  task automatic t_halt_drop();
    cpu_halted = 1'b1;
    issue(16'h0777, 16'h0101);
    cyc(1);
    chk(steal_req == 1'b1, "R9 req up", steal_req, 1);
    cpu_halted = 1'b0;
    cyc(2);
    chk(steal_req == 1'b1, "R9 req before drop edge", steal_req, 1);
    cyc(1);
    chk(steal_req == 1'b0, "R9 req dropped", steal_req, 0);
    cyc(3);
    chk(steal_req == 1'b0 && err == 1'b0, "R9 stays down", steal_req, 0);
    cpu_halted = 1'b1;
    cyc(2);
    chk(steal_req == 1'b0, "R9 re-raise early", steal_req, 0);
    cyc(1);
    chk(steal_req == 1'b1, "R9 re-raised", steal_req, 1);
    complete_access("haltdrop");
  endtask

  task automatic t_timeout(input int lim);
    int n = 0;
    int expv;
    expv = (lim < 1) ? 1 : lim;
    timeout_lim = TW'(lim);
    cpu_halted = 1'b1;
    issue(16'h0AAA, 16'h0BBB);
    cyc(1);
    while (steal_req && n < 1000) begin
      n++;
      cyc(1);
    end
    chk(n == expv, "R8 request length", n, expv);
    chk(err == 1'b1, "R8 err pulse", err, 1);
    cyc(1);
    chk(err == 1'b0, "R8 err width", err, 0);
    chk(cmd_ready == 1'b1 && steal_req == 1'b0, "R8 back to idle", cmd_ready, 1);
    timeout_lim = 8'd200;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_running_block();
    t_halt_drop();
    t_timeout(5);
    t_timeout(0);
    t_basic();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule